// File: doc/BRIEF.md
# Protection FET Control Arbiter

This block makes the final on/off decision for the charge and discharge power FETs of a battery protector. Every clock it combines protection fault flags (already reduced to the faults enabled against each FET), a low-current flag, a per-FET body-diode overcurrent flag, host on/off commands, a per-FET host control register and an 8-bit options byte. From these it produces one registered drive request per FET.

The block holds a one-bit autonomous-control state. When this state is 1, the FETs follow the protection rules and the permitted host overrides. When it is 0, the block is in test mode and each FET follows the host control register. The state is reloaded from the options byte when configuration mode is left, and a subcommand pulse inverts it. The block also gates a manual fault-recovery request against the sealed security state and returns a one-cycle clear pulse for the latched fault flags.

Top module: `fet_arbiter`

## Requirements
- R1: Synchronous active-high reset drives `chg_on`, `dsg_on`, `auto_active` and `fault_clear` to 0, and they stay 0 while reset is held.
- R2: On a cycle with `cfg_exit` high, `auto_active` takes the value of `cfg[2]` on the next clock, even if `auto_toggle` is also high in that cycle.
- R3: On a cycle with `auto_toggle` high and `cfg_exit` low, `auto_active` inverts on the next clock. With neither pulse, it holds its value.
- R4: With `auto_active` = 0 (test mode), `chg_on` follows `host_fet[0]` and `dsg_on` follows `host_fet[1]`. Faults, host commands and low current then have no effect.
- R5: With `cfg[3]` = 1 (series mode), a high `bd_chg` or `bd_dsg` forces the matching FET on in either mode. With `cfg[3]` = 0 (parallel mode), both body-diode flags are ignored.
- R6: In autonomous mode, a FET whose fault input is high is off unless R5 applies. This holds even when a permitted host force-on is present.
- R7: In autonomous mode, `host_off` turns both fault-free FETs off only when `cfg[6]` = 1. Otherwise `host_off` is ignored.
- R8: In autonomous mode, `host_on` turns both fault-free FETs on only when `cfg[5]` = 1, and a permitted `host_on` wins over a permitted `host_off`. Otherwise `host_on` is ignored.
- R9: In autonomous mode, with `cfg[4]` = 0, `low_current` = 1 and no permitted host force-on, the charge FET is off. With `cfg[4]` = 1 it may stay on. The discharge FET never depends on `low_current`.
- R10: `chg_on` and `dsg_on` are registered and reflect the inputs and the `auto_active` value of the previous clock. With no faults or commands in autonomous mode, both are on.
- R11: `fault_clear` is high for exactly the one cycle after a cycle where `recover_req` is high, and only when `sealed` = 0 or `cfg[0]` = 1. When `sealed` = 1 and `cfg[0]` = 0, the request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg | input | 8 | Options byte (b6 off allowed, b5 on allowed, b4 keep charge FET at low current, b3 series, b2 autonomous default, b0 recover while sealed) |
| fault_chg | input | 1 | Enabled fault acting on the charge FET |
| fault_dsg | input | 1 | Enabled fault acting on the discharge FET |
| low_current | input | 1 | Current magnitude below the low-current level |
| bd_chg | input | 1 | Body-diode overcurrent through the charge FET |
| bd_dsg | input | 1 | Body-diode overcurrent through the discharge FET |
| host_off | input | 1 | Host force-off command |
| host_on | input | 1 | Host force-on command |
| host_fet | input | 2 | Host FET control register (b0 charge, b1 discharge) |
| cfg_exit | input | 1 | Configuration mode exit pulse |
| auto_toggle | input | 1 | Autonomous-control toggle pulse |
| sealed | input | 1 | Security state is sealed |
| recover_req | input | 1 | Manual protection-recovery request |
| chg_on | output | 1 | Charge FET drive request |
| dsg_on | output | 1 | Discharge FET drive request |
| auto_active | output | 1 | Active autonomous-control state |
| fault_clear | output | 1 | One-cycle clear pulse for latched faults |

## Verification
The priority chain is exercised by directed phases that each hold one input at a time against its opposite: a fault against a permitted force-on, force-on against force-off, each command with its enable bit clear and then set, and low current with the keep-on bit clear and then set. These phases separate a wrong priority order from a missing enable gate. The body-diode flags are driven in both series and parallel mode, and in both test and autonomous mode, so that the series-only exception can be told apart from an unconditional override. A long random phase toggles all inputs, including simultaneous exit and toggle pulses, and compares against a behavioural model each cycle. This catches ordering and one-cycle latency errors.

// File: rtl/fet_arb_pkg.sv
package fet_arb_pkg;
  localparam int CFG_W        = 8;
  localparam int NUM_FET      = 2;
  localparam int FET_CHG      = 0;
  localparam int FET_DSG      = 1;
  // options byte bit positions
  localparam int B_RECOVER    = 0;
  localparam int B_AUTO_DEF   = 2;
  localparam int B_SERIES     = 3;
  localparam int B_KEEP_LO    = 4;
  localparam int B_HOST_ON    = 5;
  localparam int B_HOST_OFF   = 6;
  localparam int B_CHG_DET    = 7;
  localparam logic [CFG_W-1:0] CFG_RESET = 8'h18;
endpackage

// File: rtl/fet_auto_state.sv
module fet_auto_state (
  input  logic clk,
  input  logic rst,
  input  logic load_val,
  input  logic cfg_exit,
  input  logic auto_toggle,
  output logic auto_q
);
  always_ff @(posedge clk) begin
    if (rst)              auto_q <= 1'b0;
    else if (cfg_exit)    auto_q <= load_val;
    else if (auto_toggle) auto_q <= ~auto_q;
  end

  p_load_on_exit_r2: assert property (@(posedge clk) disable iff (rst)
    cfg_exit |=> auto_q == $past(load_val));
  p_toggle_inverts_r3: assert property (@(posedge clk) disable iff (rst)
    (auto_toggle && !cfg_exit) |=> auto_q != $past(auto_q));
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!auto_toggle && !cfg_exit) |=> $stable(auto_q));
endmodule

// File: rtl/fet_path.sv
module fet_path #(
  parameter bit USE_LOW_CURRENT = 1'b0
) (
  input  logic auto_mode,
  input  logic series,
  input  logic bd_flag,
  input  logic fault,
  input  logic on_ok,
  input  logic off_ok,
  input  logic low_current,
  input  logic keep_lo,
  input  logic host_bit,
  output logic drive_nxt
);
  logic lo_block;

  generate
    if (USE_LOW_CURRENT) begin : g_lo
      assign lo_block = low_current & ~keep_lo;
    end else begin : g_no_lo
      assign lo_block = 1'b0;
    end
  endgenerate

  always_comb begin
    if (series && bd_flag)  drive_nxt = 1'b1;
    else if (!auto_mode)    drive_nxt = host_bit;
    else if (fault)         drive_nxt = 1'b0;
    else if (on_ok)         drive_nxt = 1'b1;
    else if (off_ok)        drive_nxt = 1'b0;
    else if (lo_block)      drive_nxt = 1'b0;
    else                    drive_nxt = 1'b1;
  end
endmodule

// File: rtl/fet_recovery_gate.sv
module fet_recovery_gate (
  input  logic clk,
  input  logic rst,
  input  logic recover_req,
  input  logic sealed,
  input  logic allow_sealed,
  output logic clear_q
);
  logic accept;
  assign accept = recover_req & (~sealed | allow_sealed);

  always_ff @(posedge clk) begin
    if (rst) clear_q <= 1'b0;
    else     clear_q <= accept;
  end

  p_sealed_blocks_r11: assert property (@(posedge clk) disable iff (rst)
    (sealed && !allow_sealed) |=> !clear_q);
  p_unsealed_accepts_r11: assert property (@(posedge clk) disable iff (rst)
    (recover_req && !sealed) |=> clear_q);
  p_no_req_no_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    !recover_req |=> !clear_q);
endmodule

// File: rtl/fet_arbiter.sv
module fet_arbiter
  import fet_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg,
  input  logic             fault_chg,
  input  logic             fault_dsg,
  input  logic             low_current,
  input  logic             bd_chg,
  input  logic             bd_dsg,
  input  logic             host_off,
  input  logic             host_on,
  input  logic [1:0]       host_fet,
  input  logic             cfg_exit,
  input  logic             auto_toggle,
  input  logic             sealed,
  input  logic             recover_req,
  output logic             chg_on,
  output logic             dsg_on,
  output logic             auto_active,
  output logic             fault_clear
);
  logic [NUM_FET-1:0] fault_v, bd_v, nxt_v, fet_q;
  logic on_ok, off_ok;

  assign fault_v = {fault_dsg, fault_chg};
  assign bd_v    = {bd_dsg, bd_chg};
  assign on_ok   = host_on  & cfg[B_HOST_ON];
  assign off_ok  = host_off & cfg[B_HOST_OFF];

  fet_auto_state u_state (
    .clk(clk), .rst(rst), .load_val(cfg[B_AUTO_DEF]),
    .cfg_exit(cfg_exit), .auto_toggle(auto_toggle), .auto_q(auto_active)
  );

  generate
    for (genvar i = 0; i < NUM_FET; i++) begin : g_fet
      fet_path #(.USE_LOW_CURRENT(i == FET_CHG)) u_path (
        .auto_mode(auto_active), .series(cfg[B_SERIES]), .bd_flag(bd_v[i]),
        .fault(fault_v[i]), .on_ok(on_ok), .off_ok(off_ok),
        .low_current(low_current), .keep_lo(cfg[B_KEEP_LO]),
        .host_bit(host_fet[i]), .drive_nxt(nxt_v[i])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) fet_q <= '0;
    else     fet_q <= nxt_v;
  end

  assign chg_on = fet_q[FET_CHG];
  assign dsg_on = fet_q[FET_DSG];

  fet_recovery_gate u_recover (
    .clk(clk), .rst(rst), .recover_req(recover_req), .sealed(sealed),
    .allow_sealed(cfg[B_RECOVER]), .clear_q(fault_clear)
  );

  p_reset_off_r1: assert property (@(posedge clk)
    rst |=> (!chg_on && !dsg_on && !auto_active && !fault_clear));
  p_bd_series_r5: assert property (@(posedge clk) disable iff (rst)
    (cfg[B_SERIES] && bd_dsg) |=> dsg_on);
  p_fault_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (auto_active && fault_chg && !(cfg[B_SERIES] && bd_chg)) |=> !chg_on);
  p_test_follow_r4: assert property (@(posedge clk) disable iff (rst)
    (!auto_active && !(cfg[B_SERIES] && bd_dsg)) |=> dsg_on == $past(host_fet[1]));
  p_idle_on_r10: assert property (@(posedge clk) disable iff (rst)
    (auto_active && !fault_dsg && !host_on && !host_off) |=> dsg_on);
endmodule

// File: tb/test_fet_arbiter.sv
module test_fet_arbiter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] cfg = 8'h18;
  logic fault_chg = 0, fault_dsg = 0, low_current = 0, bd_chg = 0, bd_dsg = 0;
  logic host_off = 0, host_on = 0, cfg_exit = 0, auto_toggle = 0;
  logic sealed = 0, recover_req = 0;
  logic [1:0] host_fet = 2'b00;
  logic chg_on, dsg_on, auto_active, fault_clear;

  int vectors = 0, errors = 0;
  string tag = "R1";
  bit m_auto = 0, m_chg = 0, m_dsg = 0, m_clr = 0;

  always #4 clk = ~clk;

  fet_arbiter i_fet_arbiter (
    .clk(clk), .rst(rst), .cfg(cfg), .fault_chg(fault_chg), .fault_dsg(fault_dsg),
    .low_current(low_current), .bd_chg(bd_chg), .bd_dsg(bd_dsg),
    .host_off(host_off), .host_on(host_on), .host_fet(host_fet),
    .cfg_exit(cfg_exit), .auto_toggle(auto_toggle), .sealed(sealed),
    .recover_req(recover_req), .chg_on(chg_on), .dsg_on(dsg_on),
    .auto_active(auto_active), .fault_clear(fault_clear)
  );

  function automatic bit decide(bit is_chg, bit flt, bit bd, bit hbit);
    if (cfg[3] && bd) return 1;
    if (!m_auto) return hbit;
    if (flt) return 0;
    if (host_on && cfg[5]) return 1;
    if (host_off && cfg[6]) return 0;
    if (is_chg && low_current && !cfg[4]) return 0;
    return 1;
  endfunction

  task automatic cmp(string what, bit got, bit exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic step(int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      if (rst) begin
        m_auto = 0; m_chg = 0; m_dsg = 0; m_clr = 0;
      end else begin
        bit na;
        m_chg = decide(1, fault_chg, bd_chg, host_fet[0]);
        m_dsg = decide(0, fault_dsg, bd_dsg, host_fet[1]);
        m_clr = recover_req && (!sealed || cfg[0]);
        na = cfg_exit ? cfg[2] : (auto_toggle ? !m_auto : m_auto);
        m_auto = na;
      end
      @(negedge clk);
      cmp("chg_on", chg_on, m_chg);
      cmp("dsg_on", dsg_on, m_dsg);
      cmp("auto_active", auto_active, m_auto);
      cmp("fault_clear", fault_clear, m_clr);
      cfg_exit = 0; auto_toggle = 0; recover_req = 0;
    end
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    tag = "R1"; step(3);
    rst = 0;
    // R4 test mode: host register drives FETs, faults ignored
    tag = "R4"; host_fet = 2'b01; fault_chg = 1; host_off = 1; cfg[6] = 1; step(2);
    host_fet = 2'b10; step(2);
    fault_chg = 0; host_off = 0;
    // R5 body diode in test mode, series then parallel
    tag = "R5"; host_fet = 2'b00; bd_chg = 1; cfg[3] = 1; step(2);
    cfg[3] = 0; step(2); bd_chg = 0;
    // R2 load autonomous default on exit, exit beats toggle
    tag = "R2"; cfg[2] = 1; cfg_exit = 1; auto_toggle = 1; step(1); step(1);
    // R10 idle autonomous: both on one cycle later
    tag = "R10"; step(3);
    // R6 fault beats permitted force-on
    tag = "R6"; cfg[5] = 1; host_on = 1; fault_dsg = 1; step(2);
    fault_dsg = 0; host_on = 0;
    // R7 force-off gated by cfg[6]
    tag = "R7"; cfg[6] = 0; host_off = 1; step(2); cfg[6] = 1; step(2);
    // R8 force-on gated by cfg[5], wins over force-off
    tag = "R8"; cfg[5] = 0; host_on = 1; step(2); cfg[5] = 1; step(2);
    host_on = 0; host_off = 0;
    // R9 low current with keep bit clear/set
    tag = "R9"; low_current = 1; cfg[4] = 0; step(2); cfg[4] = 1; step(2);
    cfg[4] = 0; host_on = 1; step(2); host_on = 0; low_current = 0;
    // R5 body diode in autonomous mode with a fault
    tag = "R5"; cfg[3] = 1; fault_dsg = 1; bd_dsg = 1; step(2);
    cfg[3] = 0; step(2); fault_dsg = 0; bd_dsg = 0;
    // R3 toggle
    tag = "R3"; auto_toggle = 1; step(1); step(2); auto_toggle = 1; step(1);
    // R11 recovery gating
    tag = "R11"; sealed = 0; cfg[0] = 0; recover_req = 1; step(2);
    sealed = 1; recover_req = 1; step(2);
    cfg[0] = 1; recover_req = 1; step(2);
    // random mixture
    tag = "R10";
    for (int i = 0; i < 4000; i++) begin
      cfg = 8'($urandom);
      {fault_chg, fault_dsg, low_current, bd_chg, bd_dsg} = 5'($urandom);
      {host_off, host_on, sealed, recover_req} = 4'($urandom);
      host_fet = 2'($urandom);
      cfg_exit = ($urandom % 8) == 0;
      auto_toggle = ($urandom % 6) == 0;
      step(1);
    end
    tag = "R1"; rst = 1; step(2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule